// File: doc/BRIEF.md
# Dual-Source Shared Host Interrupt

This block merges two interrupt sources onto one level-sensitive host interrupt line. The first source is the "output full" condition, raised when the controller places a byte where the host can fetch it. The second is a controller attention request, which the controller can raise or withdraw at any time. Each source keeps a visible status bit and a separate "armed" flag. The armed flag records whether that source currently holds the interrupt line.

Each source is acknowledged by a different host access. A host read of the data location retires the output-full source completely. A host read of the status location only disarms the attention source, so its status bit stays visible until the controller withdraws it. Arming is gated by a strap that says whether interrupts are wired at all, and by a run-time global enable. The enable only blocks new arming, so a source that is already holding the line is never dropped by turning the enable off. All pins are plain level or single-cycle control signals, with no data stream and so no back-pressure.

Top module: `dual_src_irq`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears both status bits and both armed flags, so irq_o, ofull_o and attn_o all read 0.
- R2: irq_o is high while either source is armed. It falls only once both sources are disarmed.
- R3: A cycle with ofull_set_i high always sets ofull_o on the next edge. It arms the output-full source only when irq_use_i and irq_en_i are both high.
- R4: A cycle with rd_data_i high, and no output-full set in the same cycle, clears ofull_o and disarms the output-full source.
- R5: A cycle with rd_status_i high disarms the attention source and leaves attn_o unchanged.
- R6: A cycle with attn_set_i high always sets attn_o. It arms the attention source only when attn_irq_req_i, irq_use_i and irq_en_i are all high.
- R7: A cycle with attn_clr_i high, and no attention set in the same cycle, clears attn_o and disarms the attention source.
- R8: Dropping irq_en_i leaves an already armed source armed, so irq_o stays high.
- R9: When a set and a clear of the same source fall in the same cycle, the set wins: the status bit ends at 1, and the source is armed if the set qualifies to arm.
- R10: With irq_use_i low, no source becomes armed. irq_o then stays low while both status bits still follow their set and clear events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ofull_set_i | input | 1 | Single-cycle pulse: controller has filled the host output byte |
| attn_set_i | input | 1 | Single-cycle pulse: controller raises attention |
| attn_clr_i | input | 1 | Single-cycle pulse: controller withdraws attention |
| attn_irq_req_i | input | 1 | Qualifies attn_set_i: this attention request may interrupt |
| irq_en_i | input | 1 | Global run-time interrupt enable; gates new arming only |
| irq_use_i | input | 1 | Static strap: the interrupt line is wired and in use |
| rd_data_i | input | 1 | Single-cycle strobe: host read of the data location |
| rd_status_i | input | 1 | Single-cycle strobe: host read of the status location |
| irq_o | output | 1 | Level-sensitive host interrupt line |
| ofull_o | output | 1 | Output-full status bit |
| attn_o | output | 1 | Attention status bit |

## Verification
A wrong armed flag cannot be read directly. It shows at irq_o one edge after the offending event, either as a line that stays high after both acknowledging reads, or as a line that never rises after a qualifying set. The stimulus therefore retires the two sources in both orders. It checks that the line stays up after the first acknowledge and falls right after the second. A status bit that is cleared by the wrong read shows on ofull_o or attn_o on the very next edge. Same-cycle set and clear collisions and enable or strap changes are each applied against a known prior state.

// File: rtl/dual_src_irq_pkg.sv
package dual_src_irq_pkg;

  localparam int NUM_SRC  = 2;
  localparam int SRC_FULL = 0;
  localparam int SRC_ATTN = 1;

  // Per-source control bundle for one clock cycle.
  typedef struct packed {
    logic set;       // raise status bit
    logic qual;      // set may also arm the source
    logic clr_stat;  // drop status bit
    logic disarm;    // release hold on the interrupt line
  } src_ctl_t;

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import dual_src_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_ctl_t ctl,
  output logic     status_q,
  output logic     armed_q
);

  logic arm_now;
  assign arm_now = ctl.set & ctl.qual;

  // Status: set has priority over clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            status_q <= 1'b0;
    else if (ctl.set)      status_q <= 1'b1;
    else if (ctl.clr_stat) status_q <= 1'b0;
  end

  // Armed flag: a qualifying set has priority over any disarm.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          armed_q <= 1'b0;
    else if (arm_now)    armed_q <= 1'b1;
    else if (ctl.disarm) armed_q <= 1'b0;
  end

endmodule

// File: rtl/irq_level_merge.sv
module irq_level_merge #(
  parameter int N = 2
) (
  input  logic [N-1:0] armed,
  output logic         irq
);

  assign irq = |armed;

endmodule

// File: rtl/dual_src_irq.sv
module dual_src_irq
  import dual_src_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ofull_set_i,
  input  logic attn_set_i,
  input  logic attn_clr_i,
  input  logic attn_irq_req_i,
  input  logic irq_en_i,
  input  logic irq_use_i,
  input  logic rd_data_i,
  input  logic rd_status_i,
  output logic irq_o,
  output logic ofull_o,
  output logic attn_o
);

  src_ctl_t           ctl    [NUM_SRC];
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] armed_q;
  logic               gate_ok;

  assign gate_ok = irq_use_i & irq_en_i;

  // Output-full: both status and hold retired by a data read.
  assign ctl[SRC_FULL].set      = ofull_set_i;
  assign ctl[SRC_FULL].qual     = gate_ok;
  assign ctl[SRC_FULL].clr_stat = rd_data_i;
  assign ctl[SRC_FULL].disarm   = rd_data_i;

  // Attention: a status read drops only the hold; withdraw drops both.
  assign ctl[SRC_ATTN].set      = attn_set_i;
  assign ctl[SRC_ATTN].qual     = gate_ok & attn_irq_req_i;
  assign ctl[SRC_ATTN].clr_stat = attn_clr_i;
  assign ctl[SRC_ATTN].disarm   = attn_clr_i | rd_status_i;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    irq_src_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl      (ctl[i]),
      .status_q (status_q[i]),
      .armed_q  (armed_q[i])
    );
  end

  irq_level_merge #(.N(NUM_SRC)) u_merge (
    .armed (armed_q),
    .irq   (irq_o)
  );

  assign ofull_o = status_q[SRC_FULL];
  assign attn_o  = status_q[SRC_ATTN];

endmodule

// File: rtl/dual_src_irq_chk.sv
module dual_src_irq_chk (
  input logic clk,
  input logic rst_n,
  input logic ofull_set_i,
  input logic attn_set_i,
  input logic attn_clr_i,
  input logic irq_use_i,
  input logic rd_data_i,
  input logic rd_status_i,
  input logic irq_o,
  input logic ofull_o,
  input logic attn_o
);

  // R2: a held line always has a visible status bit behind it.
  p_line_has_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ofull_o || attn_o));

  // R3: output-full set always shows.
  p_full_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ofull_set_i |=> ofull_o);

  // R4: data read retires output-full.
  p_data_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_i && !ofull_set_i) |=> !ofull_o);

  // R5: status read keeps the attention bit.
  p_status_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status_i && attn_o && !attn_clr_i) |=> attn_o);

  // R6: attention set always shows.
  p_attn_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    attn_set_i |=> attn_o);

  // R7: withdraw clears attention.
  p_attn_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (attn_clr_i && !attn_set_i) |=> !attn_o);

  // R8: with no acknowledge of any kind, a held line stays held.
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !rd_data_i && !rd_status_i && !attn_clr_i) |=> irq_o);

  // R10: strap off never raises the line.
  p_no_strap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_use_i && !irq_o) |=> !irq_o);

endmodule

bind dual_src_irq dual_src_irq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ofull_set_i (ofull_set_i),
  .attn_set_i  (attn_set_i),
  .attn_clr_i  (attn_clr_i),
  .irq_use_i   (irq_use_i),
  .rd_data_i   (rd_data_i),
  .rd_status_i (rd_status_i),
  .irq_o       (irq_o),
  .ofull_o     (ofull_o),
  .attn_o      (attn_o)
);

// File: tb/dual_src_irq_test.sv
`timescale 1ns/1ps
module dual_src_irq_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ofull_set_i = 1'b0, attn_set_i = 1'b0, attn_clr_i = 1'b0;
  logic attn_irq_req_i = 1'b0, irq_en_i = 1'b0, irq_use_i = 1'b0;
  logic rd_data_i = 1'b0, rd_status_i = 1'b0;
  logic irq_o, ofull_o, attn_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_src_irq uut (
    .clk(clk), .rst_n(rst_n),
    .ofull_set_i(ofull_set_i), .attn_set_i(attn_set_i), .attn_clr_i(attn_clr_i),
    .attn_irq_req_i(attn_irq_req_i), .irq_en_i(irq_en_i), .irq_use_i(irq_use_i),
    .rd_data_i(rd_data_i), .rd_status_i(rd_status_i),
    .irq_o(irq_o), .ofull_o(ofull_o), .attn_o(attn_o)
  );

  // Stimulus bits [10:3]: ofull_set attn_set attn_clr attn_req en use rd_data rd_status
  // Expected bits [2:0]:  irq ofull attn
  localparam int NV = 20;
  localparam logic [10:0] VEC [NV] = '{
    11'b10001100_110,  // R3 arm full
    11'b00001101_110,  // R5 status read leaves full source
    11'b00001110_000,  // R4 data read retires full
    11'b10000100_010,  // R3 enable off: status only
    11'b00000110_000,  // R4
    11'b01001100_001,  // R6 no request: status only
    11'b01011100_101,  // R6 arm attention
    11'b00001101_001,  // R5 disarm, bit kept
    11'b00101100_000,  // R7 withdraw
    11'b01011100_101,  // R6
    11'b10001100_111,  // R2 both armed
    11'b00001101_111,  // R2 one disarmed, line held
    11'b00000100_111,  // R8 enable dropped, still held
    11'b00000110_001,  // R2 both disarmed, line falls
    11'b01111100_101,  // R9 attention set beats clear
    11'b10001110_111,  // R9 full set beats data read
    11'b00101000_110,  // R7 withdraw, full still held
    11'b00001010_000,  // R4
    11'b10001000_010,  // R10 strap off
    11'b01011000_011   // R10 strap off
  };
  localparam int TAG [NV] = '{3,5,4,3,4,6,6,5,7,6,2,2,8,2,9,9,7,4,10,10};

  task automatic check3(input logic [2:0] exp, input int tag);
    n_vec++;
    if ({irq_o, ofull_o, attn_o} !== exp) begin
      n_bad++;
      $display("FAIL R%0d: {irq,ofull,attn} got %b expected %b", tag,
               {irq_o, ofull_o, attn_o}, exp);
    end
  endtask

  task automatic apply(input logic [7:0] s, input logic [2:0] exp, input int tag);
    @(negedge clk);
    {ofull_set_i, attn_set_i, attn_clr_i, attn_irq_req_i,
     irq_en_i, irq_use_i, rd_data_i, rd_status_i} = s;
    @(posedge clk);
    #1;
    check3(exp, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check3(3'b000, 1);  // R1 reset state
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) apply(VEC[i][10:3], VEC[i][2:0], TAG[i]);

    // R1: reset mid-operation with both sources armed
    apply(8'b11011100, 3'b111, 2);
    @(negedge clk);
    {ofull_set_i, attn_set_i, attn_clr_i, attn_irq_req_i,
     irq_en_i, irq_use_i, rd_data_i, rd_status_i} = '0;
    rst_n = 1'b0;
    #1;
    check3(3'b000, 1);
    @(negedge clk);
    rst_n = 1'b1;
    apply(8'b00000000, 3'b000, 1);  // R1 stays clear after release
    // R3 rearm after reset, then R4 retire
    apply(8'b10001100, 3'b110, 3);
    apply(8'b00001110, 3'b000, 4);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule